// File: doc/BRIEF.md
# Condition Run-Length Meter

The block measures how long a qualified condition stays true. A typical condition is a cycle in which no instruction retires. While the condition bit is high, a saturating cycle counter advances once per clock. On the first cycle in which the condition is low again, the length of the run is captured into an output register and marked by a one-cycle valid strobe. The value then goes on to ordinary event filtering, such as a threshold compare.

Each run yields one value, not a running count, so rare long stretches show up as single large samples. The enable input qualifies the measurement. Dropping the enable in the middle of a run throws that run away, and no sample is produced for it. The captured length stays on the output until the next sample replaces it.

Top module: `cond_run_meter`

## Requirements
- R1: After reset, `len_o` is 0 and `valid_o` is 0.
- R2: A run of N consecutive clock edges with `en_i`=1 and `cond_i`=1, followed by an edge with `en_i`=1 and `cond_i`=0, produces a sample equal to N (for N up to 2^CNT_W-1).
- R3: `valid_o` is high for exactly one cycle. That cycle directly follows the first edge at which the condition is seen low. Each run gives exactly one pulse.
- R4: Every new run starts counting from 1, even when only one low cycle separates it from the previous run.
- R5: The run counter saturates at 2^CNT_W-1 and does not wrap. A longer run reports 2^CNT_W-1.
- R6: An edge with `en_i`=0 ends any run in progress without a sample. This holds when the condition falls on that same edge. A run starting after re-enable counts from 1.
- R7: Between samples, `len_o` keeps its last captured value.
- R8: While `en_i`=0, activity on `cond_i` produces no sample and leaves `len_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Measurement enable |
| cond_i | input | 1 | Qualified condition, one bit per cycle |
| len_o | output | CNT_W | Length of the last completed run |
| valid_o | output | 1 | One-cycle strobe marking a new `len_o` |

## Verification
Runs of several lengths, each separated by a long gap, confirm that the reported value equals the run length. Runs separated by a single low cycle show that the counter restarts at 1 and that the strobe appears once per run. Runs at, one beyond and well beyond the counter maximum separate saturation from wrap-around. Two enable patterns show that a disable discards a run rather than shortening it: one drops the enable inside a run, the other drops it on the same edge the condition falls. Condition toggling while disabled, and idle gaps, show that the output register holds its value.

// File: rtl/cond_run_meter_pkg.sv
package cond_run_meter_pkg;
  typedef enum logic {
    RUN_IDLE = 1'b0,
    RUN_ACTIVE = 1'b1
  } run_state_e;
endpackage

// File: rtl/crm_sat_counter.sv
module crm_sat_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             start_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_o <= '0;
    else if (clear_i)                    cnt_o <= '0;
    else if (start_i)                    cnt_o <= CNT_W'(1);
    else if (step_i && cnt_o != CntMax)  cnt_o <= cnt_o + 1'b1;
  end

  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clear_i && !start_i && cnt_o == CntMax) |=> (cnt_o == CntMax)); // R5

  AST_START_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !clear_i) |=> (cnt_o == CNT_W'(1))); // R4
endmodule

// File: rtl/crm_run_tracker.sv
module crm_run_tracker
  import cond_run_meter_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic cond_i,
  output logic clear_o,
  output logic start_o,
  output logic step_o,
  output logic end_o
);
  run_state_e state_q, state_d;

  always_comb begin
    clear_o = !en_i;
    start_o = en_i && cond_i && (state_q == RUN_IDLE);
    step_o  = en_i && cond_i && (state_q == RUN_ACTIVE);
    end_o   = en_i && !cond_i && (state_q == RUN_ACTIVE);
    state_d = (en_i && cond_i) ? RUN_ACTIVE : RUN_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= RUN_IDLE;
    else         state_q <= state_d;
  end

  AST_ONE_ACTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_o, step_o, end_o})); // R3

  AST_END_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |-> $past(en_i && cond_i)); // R2
endmodule

// File: rtl/crm_sample_hold.sv
module crm_sample_hold #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             capture_i,
  input  logic [CNT_W-1:0] data_i,
  output logic [CNT_W-1:0] len_o,
  output logic             valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= capture_i;
      if (capture_i) len_o <= data_i;
    end
  end

  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(len_o)); // R7
endmodule

// File: rtl/cond_run_meter.sv
module cond_run_meter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             cond_i,
  output logic [CNT_W-1:0] len_o,
  output logic             valid_o
);
  logic             clear, start, step, run_end;
  logic [CNT_W-1:0] cnt;

  crm_run_tracker i_tracker (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .cond_i (cond_i),
    .clear_o(clear),
    .start_o(start),
    .step_o (step),
    .end_o  (run_end)
  );

  crm_sat_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clear),
    .start_i(start),
    .step_i (step),
    .cnt_o  (cnt)
  );

  crm_sample_hold #(.CNT_W(CNT_W)) i_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .capture_i(run_end),
    .data_i   (cnt),
    .len_o    (len_o),
    .valid_o  (valid_o)
  );

  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R3

  AST_DISABLE_NO_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !valid_o); // R6

  AST_NONZERO_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (len_o != '0)); // R2
endmodule

// File: tb/test_cond_run_meter.sv
module test_cond_run_meter;
  localparam int W   = 4;
  localparam int MAX = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0;
  logic         cond = 1'b0;
  logic [W-1:0] len;
  logic         valid;

  int checks = 0;
  int fails = 0;
  int exp_q[$];
  string tag_q[$];
  bit done = 1'b0;

  always #2 clk = ~clk;

  cond_run_meter #(.CNT_W(W)) i_cond_run_meter (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .en_i   (en),
    .cond_i (cond),
    .len_o  (len),
    .valid_o(valid)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every strobe
  always @(negedge clk) begin
    if (rst_n && valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6/R8 unexpected sample", int'(len), -1);
      end else begin
        automatic int e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(int'(len) == e, t, int'(len), e);
      end
    end
  end

  function automatic int sat(int n);
    return (n > MAX) ? MAX : n;
  endfunction

  // driver: run of n true cycles then gap low cycles
  task automatic burst(int n, int gap, string tag);
    cond = 1'b1;
    repeat (n) @(negedge clk);
    exp_q.push_back(sat(n));
    tag_q.push_back(tag);
    cond = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic quiet(int n, string tag, int held);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(valid == 1'b0, tag, int'(valid), 0);
      check(int'(len) == held, tag, int'(len), held);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(valid == 1'b0, "R1 valid", int'(valid), 0);
    check(len == '0, "R1 len", int'(len), 0);
    rst_n = 1'b1;
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);

    // R2 lengths
    burst(1, 4, "R2 len1");
    burst(5, 4, "R2 len5");
    burst(9, 4, "R2 len9");

    // R3 strobe timing
    cond = 1'b1;
    repeat (3) @(negedge clk);
    exp_q.push_back(3); tag_q.push_back("R3 len3");
    cond = 1'b0;
    check(valid == 1'b0, "R3 before", int'(valid), 0);
    @(negedge clk);
    check(valid == 1'b1, "R3 strobe", int'(valid), 1);
    @(negedge clk);
    check(valid == 1'b0, "R3 single", int'(valid), 0);

    // R7 hold
    quiet(6, "R7 hold", 3);

    // R4 back-to-back runs
    burst(3, 1, "R4 first");
    burst(2, 1, "R4 restart");
    burst(4, 3, "R4 third");

    // R5 saturation
    burst(MAX, 3, "R5 at max");
    burst(MAX + 1, 3, "R5 max+1");
    burst(3 * MAX, 3, "R5 long");

    // R6 disable inside a run
    cond = 1'b1;
    repeat (5) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    en = 1'b1;
    repeat (3) @(negedge clk);
    exp_q.push_back(3); tag_q.push_back("R6 fresh after reenable");
    cond = 1'b0;
    repeat (3) @(negedge clk);

    // R6 disable on the falling edge of the condition
    cond = 1'b1;
    repeat (6) @(negedge clk);
    en = 1'b0;
    cond = 1'b0;
    quiet(4, "R6 discarded", 3);

    // R8 condition toggles while disabled
    for (int i = 0; i < 8; i++) begin
      cond = i[0];
      @(negedge clk);
      check(valid == 1'b0, "R8 no sample", int'(valid), 0);
      check(int'(len) == 3, "R8 len kept", int'(len), 3);
    end
    cond = 1'b0;
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    burst(2, 3, "R8 after enable");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R2 missing samples", exp_q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule